// File: doc/BRIEF.md
# Interrupt and Reset Sequencer

This block is the control unit that sits next to the execution core of an 8-bit accumulator processor. At every instruction boundary it picks one of four actions: the start-up sequence after reset, entry to the non-maskable interrupt, entry to the maskable interrupt, or a plain opcode fetch. It also holds the processor in a wait-for-interrupt state or a stopped state when the core asks for either. The unit owns the program counter, the stack pointer and the status flags for the cycles it runs. The core loads the status flags through a load port while no sequence is running.

The unit uses a single memory bus and makes at most one access per clock. Address, write data and write enable come from registers. Read data is sampled on the clock edge that ends the access. Two qualifiers go with every access. The opcode-fetch marker is high only on fetch cycles. The active-low vector marker is low only when a handler or start-up address is being read. After a fetch the core gets the opcode with a one-cycle valid strobe, and it signals the next boundary with a strobe of its own. Opcode execution is not part of this block.

Top module: `boundary_ctl`

## Requirements
- R1: While reset is asserted, the stack pointer reads 0x00, the flags read 0x24 (bit 5 always one, bit 2 the interrupt mask), and the state code reads 0. State codes are 0 start-up pending, 1 running, 2 waiting, 3 stopped.
- R2: The start-up sequence runs after reset is released. It makes two dummy reads at the PC, then three reads at 0x0100|S with S decremented after each and no write. It then reads 0xFFFC for the new PC low byte and 0xFFFD for the high byte. It clears flag bit 3 (decimal), sets bit 2, and then runs.
- R3: A rising edge on the nmi input sets a latch. The latch stays set until non-maskable entry begins. A level that stays high does not start a second entry.
- R4: The irq input is level sensitive. It is taken at a boundary only while flag bit 2 is clear.
- R5: At a boundary, a latched nmi edge wins over an irq that can be taken, and either one wins over an opcode fetch.
- R6: An interrupt entry takes seven bus cycles. It makes two dummy reads at the PC, then writes PC high, PC low and the flags. For non-maskable entry, bit 4 of the pushed flags is cleared; maskable entry pushes the flags unchanged. After the push, bit 3 is cleared and bit 2 is set.
- R7: Non-maskable entry reads its new PC from 0xFFFA/0xFFFB and maskable entry from 0xFFFE/0xFFFF, low byte first.
- R8: Each stack cycle addresses 0x0100|S, and S is then decremented with 8-bit wraparound (0x00 goes to 0xFF).
- R9: A wait request moves the unit to waiting, which makes no bus access. The unit returns to running when irq is high, even with bit 2 set, or when the nmi latch is set. It then decides again at the next boundary.
- R10: A stop request moves the unit to stopped. In that state it makes no bus access and ignores irq and nmi. Only reset leaves it.
- R11: The opcode-fetch marker is high only on fetch reads. The vector marker is low only on the two vector reads of a sequence and high on every other cycle.
- R12: A fetch is one read at the PC with the fetch marker high. In the next cycle the opcode is presented with the valid strobe, and the PC has been incremented.
- R13: A flag load from the core takes effect on the next edge with bit 5 forced to one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_i | input | 1 | Maskable interrupt request, logical level |
| nmi_i | input | 1 | Non-maskable interrupt request, logical level |
| boundary_i | input | 1 | Core finished an instruction |
| wai_req_i | input | 1 | Core requests the waiting state |
| stp_req_i | input | 1 | Core requests the stopped state |
| p_load_i | input | 1 | Load flags from p_new_i |
| p_new_i | input | 8 | New flag value |
| rdata_i | input | 8 | Read data from memory |
| bus_req_o | output | 1 | An access is on the bus this cycle |
| addr_o | output | 16 | Access address |
| we_o | output | 1 | Write enable |
| wdata_o | output | 8 | Write data |
| sync_o | output | 1 | Opcode-fetch marker |
| vpb_o | output | 1 | Vector-read marker, active low |
| opcode_o | output | 8 | Last fetched opcode |
| fetch_valid_o | output | 1 | opcode_o is new this cycle |
| pc_o | output | 16 | Program counter |
| s_o | output | 8 | Stack pointer |
| p_o | output | 8 | Status flags |
| dbg_state_o | output | 2 | State code for the testbench |

## Verification
The properties assume that the core raises wai, stop and boundary requests only while the unit is idle in running, and that memory answers each read within the cycle the address is shown. The stimulus keeps to this. It pulses each request for exactly one cycle, and only after the expected accesses of the previous action have drained. A behavioural memory returns the vector bytes and a fixed function of the address for everything else. The irq and nmi inputs change one cycle before the boundary strobe, so the edge latch has settled by the time the decision is made.

// File: rtl/bctl_pkg.sv
package bctl_pkg;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int SW = 3;

  localparam int F_I   = 2;
  localparam int F_D   = 3;
  localparam int F_B   = 4;
  localparam int F_ONE = 5;

  localparam logic [DW-1:0] P_AT_RESET = 8'h24;
  localparam logic [DW-1:0] STACK_HI   = 8'h01;
  localparam logic [AW-1:0] VEC_NMI    = 16'hFFFA;
  localparam logic [AW-1:0] VEC_RST    = 16'hFFFC;
  localparam logic [AW-1:0] VEC_IRQ    = 16'hFFFE;

  localparam logic [SW-1:0] STEP_PUSH0 = 3'd2;
  localparam logic [SW-1:0] STEP_PUSH2 = 3'd4;
  localparam logic [SW-1:0] STEP_VLO   = 3'd5;
  localparam logic [SW-1:0] STEP_LAST  = 3'd6;

  typedef enum logic [1:0] {
    ST_START = 2'd0,
    ST_RUN   = 2'd1,
    ST_WAIT  = 2'd2,
    ST_STOP  = 2'd3
  } st_e;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_RESET = 3'd1,
    SQ_NMI   = 3'd2,
    SQ_IRQ   = 3'd3,
    SQ_FETCH = 3'd4
  } sq_e;

  typedef struct packed {
    logic          req;
    logic [AW-1:0] addr;
    logic          we;
    logic [DW-1:0] wdata;
    logic          sync;
    logic          vpb;
  } bus_t;
endpackage

// File: rtl/bctl_rst_sync.sv
module bctl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/bctl_nmi_latch.sv
module bctl_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_i,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q, pend_q;
  logic pend_d;

  always_comb begin
    pend_d = (nmi_i && !prev_q) || (pend_q && !clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= nmi_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/bctl_bus_map.sv
module bctl_bus_map
  import bctl_pkg::*;
(
  input  sq_e           kind_i,
  input  logic [SW-1:0] step_i,
  input  logic [DW-1:0] s_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] p_i,
  output bus_t          bus_o
);
  logic [AW-1:0] vec;
  logic [DW-1:0] pushed_p;

  always_comb begin
    vec = VEC_RST;
    if (kind_i == SQ_NMI) vec = VEC_NMI;
    if (kind_i == SQ_IRQ) vec = VEC_IRQ;
    pushed_p = p_i;
    if (kind_i == SQ_NMI) pushed_p[F_B] = 1'b0;
  end

  always_comb begin
    bus_o       = '0;
    bus_o.vpb   = 1'b1;
    bus_o.addr  = pc_i;
    unique case (kind_i)
      SQ_FETCH: begin
        bus_o.req  = 1'b1;
        bus_o.sync = 1'b1;
      end
      SQ_RESET, SQ_NMI, SQ_IRQ: begin
        bus_o.req = 1'b1;
        if (step_i >= STEP_PUSH0 && step_i <= STEP_PUSH2) begin
          bus_o.addr = {STACK_HI, s_i};
          bus_o.we   = (kind_i != SQ_RESET);
          unique case (step_i)
            3'd2:    bus_o.wdata = pc_i[AW-1:DW];
            3'd3:    bus_o.wdata = pc_i[DW-1:0];
            default: bus_o.wdata = pushed_p;
          endcase
          if (kind_i == SQ_RESET) bus_o.wdata = '0;
        end else if (step_i == STEP_VLO) begin
          bus_o.addr = vec;
          bus_o.vpb  = 1'b0;
        end else if (step_i == STEP_LAST) begin
          bus_o.addr = vec + 16'd1;
          bus_o.vpb  = 1'b0;
        end
      end
      default: bus_o.req = 1'b0;
    endcase
  end
endmodule

// File: rtl/boundary_ctl.sv
module boundary_ctl
  import bctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_i,
  input  logic          nmi_i,
  input  logic          boundary_i,
  input  logic          wai_req_i,
  input  logic          stp_req_i,
  input  logic          p_load_i,
  input  logic [7:0]    p_new_i,
  input  logic [7:0]    rdata_i,
  output logic          bus_req_o,
  output logic [15:0]   addr_o,
  output logic          we_o,
  output logic [7:0]    wdata_o,
  output logic          sync_o,
  output logic          vpb_o,
  output logic [7:0]    opcode_o,
  output logic          fetch_valid_o,
  output logic [15:0]   pc_o,
  output logic [7:0]    s_o,
  output logic [7:0]    p_o,
  output logic [1:0]    dbg_state_o
);
  logic srst_n;
  st_e  state_q, state_d;
  sq_e  kind_q, kind_d;
  logic [SW-1:0] step_q, step_d;
  logic [DW-1:0] s_q, s_d, p_q, p_d, vlo_q, vlo_d, opc_q, opc_d;
  logic [AW-1:0] pc_q, pc_d;
  logic bound_q, bound_d, fv_q, fv_d;
  logic nmi_pend, nmi_clr;
  bus_t bus_q, bus_d;

  bctl_rst_sync #(.STAGES(2)) u_rs (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  bctl_nmi_latch u_nmi (.clk(clk), .rst_n(srst_n), .nmi_i(nmi_i),
                        .clr_i(nmi_clr), .pend_o(nmi_pend));

  bctl_bus_map u_map (.kind_i(kind_d), .step_i(step_d), .s_i(s_d),
                      .pc_i(pc_d), .p_i(p_d), .bus_o(bus_d));

  always_comb begin
    state_d = state_q; kind_d = kind_q; step_d = step_q;
    s_d = s_q; p_d = p_q; pc_d = pc_q; vlo_d = vlo_q; opc_d = opc_q;
    bound_d = bound_q; fv_d = 1'b0; nmi_clr = 1'b0;
    unique case (kind_q)
      SQ_FETCH: begin
        opc_d  = rdata_i;
        fv_d   = 1'b1;
        pc_d   = pc_q + 16'd1;
        kind_d = SQ_IDLE;
      end
      SQ_RESET, SQ_NMI, SQ_IRQ: begin
        if (step_q >= STEP_PUSH0 && step_q <= STEP_PUSH2) s_d = s_q - 8'd1;
        if (step_q == STEP_PUSH2) begin
          p_d[F_D] = 1'b0;
          p_d[F_I] = 1'b1;
        end
        if (step_q == STEP_VLO) vlo_d = rdata_i;
        if (step_q == STEP_LAST) begin
          pc_d    = {rdata_i, vlo_q};
          kind_d  = SQ_IDLE;
          step_d  = '0;
          state_d = ST_RUN;
          bound_d = 1'b1;
        end else begin
          step_d = step_q + 3'd1;
        end
      end
      default: begin
        unique case (state_q)
          ST_START: begin
            kind_d = SQ_RESET;
            step_d = '0;
          end
          ST_RUN: begin
            if (p_load_i) begin
              p_d        = p_new_i;
              p_d[F_ONE] = 1'b1;
            end
            if (bound_q || boundary_i) begin
              bound_d = 1'b0;
              step_d  = '0;
              if (nmi_pend) begin
                kind_d  = SQ_NMI;
                nmi_clr = 1'b1;
              end else if (irq_i && !p_q[F_I]) begin
                kind_d = SQ_IRQ;
              end else begin
                kind_d = SQ_FETCH;
              end
            end else if (stp_req_i) begin
              state_d = ST_STOP;
            end else if (wai_req_i) begin
              state_d = ST_WAIT;
            end
          end
          ST_WAIT: begin
            if (irq_i || nmi_pend) begin
              state_d = ST_RUN;
              bound_d = 1'b1;
            end
          end
          default: state_d = ST_STOP;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_START;
      kind_q  <= SQ_IDLE;
      step_q  <= '0;
      s_q     <= '0;
      p_q     <= P_AT_RESET;
      pc_q    <= '0;
      vlo_q   <= '0;
      opc_q   <= '0;
      bound_q <= 1'b0;
      fv_q    <= 1'b0;
      bus_q   <= '{req: 1'b0, addr: '0, we: 1'b0, wdata: '0, sync: 1'b0, vpb: 1'b1};
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      step_q  <= step_d;
      s_q     <= s_d;
      p_q     <= p_d;
      pc_q    <= pc_d;
      vlo_q   <= vlo_d;
      opc_q   <= opc_d;
      bound_q <= bound_d;
      fv_q    <= fv_d;
      bus_q   <= bus_d;
    end
  end

  assign bus_req_o     = bus_q.req;
  assign addr_o        = bus_q.addr;
  assign we_o          = bus_q.we;
  assign wdata_o       = bus_q.wdata;
  assign sync_o        = bus_q.sync;
  assign vpb_o         = bus_q.vpb;
  assign opcode_o      = opc_q;
  assign fetch_valid_o = fv_q;
  assign pc_o          = pc_q;
  assign s_o           = s_q;
  assign p_o           = p_q;
  assign dbg_state_o   = state_q;
endmodule

// File: rtl/boundary_ctl_chk.sv
module boundary_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_req_o,
  input logic [15:0] addr_o,
  input logic        we_o,
  input logic        sync_o,
  input logic        vpb_o,
  input logic        fetch_valid_o,
  input logic [7:0]  s_o,
  input logic [1:0]  dbg_state_o
);
  // R11
  fetch_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |-> (bus_req_o && !we_o && vpb_o));
  // R11
  vector_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vpb_o |-> (bus_req_o && !we_o && !sync_o && addr_o[15:3] == 13'h1FFF));
  // R8
  push_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |-> (addr_o[15:8] == 8'h01 && addr_o[7:0] == s_o));
  // R8
  push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |=> (s_o == $past(s_o) - 8'd1));
  // R2
  start_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_state_o == 2'd0) |-> !we_o);
  // R12
  fetch_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |=> fetch_valid_o);
  // R9
  wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_state_o == 2'd2) |-> !bus_req_o);
  // R10
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_state_o == 2'd3) |-> !bus_req_o);
  // R10
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_state_o == 2'd3) |=> (dbg_state_o == 2'd3));
endmodule

bind boundary_ctl boundary_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req_o(bus_req_o), .addr_o(addr_o),
  .we_o(we_o), .sync_o(sync_o), .vpb_o(vpb_o), .fetch_valid_o(fetch_valid_o),
  .s_o(s_o), .dbg_state_o(dbg_state_o)
);

// File: tb/sim_boundary_ctl.sv
`timescale 1ns/1ps
module sim_boundary_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq = 1'b0, nmi = 1'b0, bnd = 1'b0, wai = 1'b0, stp = 1'b0, pld = 1'b0;
  logic [7:0] pnew = 8'h00;
  logic [7:0] rdata;
  logic bus_req, we, sync, vpb, fvalid;
  logic [15:0] addr, pc;
  logic [7:0] wdata, opc, s, p;
  logic [1:0] st;

  int nchk = 0, nerr = 0, cyc = 0;

  logic [15:0] q_addr[$];
  logic        q_we[$];
  logic [7:0]  q_wd[$];
  logic        q_sync[$];
  logic        q_vpb[$];
  string       q_tag[$];
  logic [7:0]  q_opc[$];

  always #5 clk = ~clk;

  boundary_ctl u0 (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .nmi_i(nmi), .boundary_i(bnd),
    .wai_req_i(wai), .stp_req_i(stp), .p_load_i(pld), .p_new_i(pnew),
    .rdata_i(rdata), .bus_req_o(bus_req), .addr_o(addr), .we_o(we),
    .wdata_o(wdata), .sync_o(sync), .vpb_o(vpb), .opcode_o(opc),
    .fetch_valid_o(fvalid), .pc_o(pc), .s_o(s), .p_o(p), .dbg_state_o(st)
  );

  always_comb begin
    unique case (addr)
      16'hFFFA: rdata = 8'h00;
      16'hFFFB: rdata = 8'h30;
      16'hFFFC: rdata = 8'h00;
      16'hFFFD: rdata = 8'h02;
      16'hFFFE: rdata = 8'h00;
      16'hFFFF: rdata = 8'h40;
      default:  rdata = addr[7:0] ^ 8'hA5;
    endcase
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic exp_acc(input logic [15:0] a, input logic w, input logic [7:0] d,
                         input logic sy, input logic vp, input string tag);
    q_addr.push_back(a); q_we.push_back(w); q_wd.push_back(d);
    q_sync.push_back(sy); q_vpb.push_back(vp); q_tag.push_back(tag);
  endtask

  task automatic exp_fetch(input logic [15:0] a);
    exp_acc(a, 1'b0, 8'h00, 1'b1, 1'b1, "R12 fetch");
    q_opc.push_back(a[7:0] ^ 8'hA5);
  endtask

  task automatic exp_reset(input logic [15:0] a, input logic [7:0] sp);
    exp_acc(a, 0, 0, 0, 1, "R2 dummy");
    exp_acc(a, 0, 0, 0, 1, "R2 dummy");
    for (int k = 0; k < 3; k++) exp_acc({8'h01, sp - 8'(k)}, 0, 0, 0, 1, "R2 R8 stack read");
    exp_acc(16'hFFFC, 0, 0, 0, 0, "R2 vector lo");
    exp_acc(16'hFFFD, 0, 0, 0, 0, "R2 vector hi");
  endtask

  task automatic exp_entry(input logic [15:0] a, input logic [7:0] sp, input logic [7:0] pp, input bit is_nmi);
    logic [15:0] v;
    v = is_nmi ? 16'hFFFA : 16'hFFFE;
    exp_acc(a, 0, 0, 0, 1, "R6 dummy");
    exp_acc(a, 0, 0, 0, 1, "R6 dummy");
    exp_acc({8'h01, sp},         1, a[15:8], 0, 1, "R6 push pch");
    exp_acc({8'h01, sp - 8'd1},  1, a[7:0],  0, 1, "R6 push pcl");
    exp_acc({8'h01, sp - 8'd2},  1, is_nmi ? (pp & 8'hEF) : pp, 0, 1, "R6 push flags");
    exp_acc(v,         0, 0, 0, 0, "R7 vector lo");
    exp_acc(v + 16'd1, 0, 0, 0, 0, "R7 vector hi");
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk) sig = 1'b1;
    @(negedge clk) sig = 1'b0;
  endtask

  task automatic drain();
    while (q_addr.size() != 0 || q_opc.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && bus_req) begin
      if (q_addr.size() == 0) begin
        chk(1'b0, "R13 unexpected access", {addr, 7'd0, we, sync, vpb}, 32'h0);
      end else begin
        logic [15:0] ea; logic ew, es, ev; logic [7:0] ed; string t;
        ea = q_addr.pop_front(); ew = q_we.pop_front(); ed = q_wd.pop_front();
        es = q_sync.pop_front(); ev = q_vpb.pop_front(); t = q_tag.pop_front();
        chk(addr == ea && we == ew && (!ew || wdata == ed) && sync == es && vpb == ev, t,
            {addr, (we ? wdata : 8'h00), 5'd0, we, sync, vpb},
            {ea, (ew ? ed : 8'h00), 5'd0, ew, es, ev});
      end
    end
    if (rst_n && fvalid) begin
      if (q_opc.size() == 0) chk(1'b0, "R12 unexpected opcode", {24'd0, opc}, 32'h0);
      else begin
        logic [7:0] eo;
        eo = q_opc.pop_front();
        chk(opc == eo, "R12 opcode", {24'd0, opc}, {24'd0, eo});
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(st == 2'd0 && s == 8'h00 && p == 8'h24, "R1 reset state", {st, s, p}, {2'd0, 8'h00, 8'h24});
    exp_reset(16'h0000, 8'h00);
    exp_fetch(16'h0200);
    rst_n = 1'b1;
    drain();
    // R2 R8 end of start-up: S wrapped 00 -> FD
    chk(st == 2'd1 && s == 8'hFD && p == 8'h24 && pc == 16'h0201, "R2 R8 after start-up",
        {st, s, p, pc}, {2'd1, 8'hFD, 8'h24, 16'h0201});

    // R4 irq masked while bit 2 set
    irq = 1'b1;
    @(negedge clk);
    exp_fetch(16'h0201);
    pulse(bnd);
    drain();
    chk(pc == 16'h0202 && s == 8'hFD, "R4 masked irq", {pc, s}, {16'h0202, 8'hFD});
    irq = 1'b0;

    // R13 flag load, bit 5 forced
    pnew = 8'h18;
    pulse(pld);
    chk(p == 8'h38, "R13 flag load", {24'd0, p}, 32'h38);

    // R5 nmi beats irq, R6 B cleared on push, D cleared
    nmi = 1'b1; irq = 1'b1;
    @(negedge clk);
    exp_entry(16'h0202, 8'hFD, 8'h38, 1'b1);
    exp_fetch(16'h3000);
    pulse(bnd);
    drain();
    chk(p == 8'h34 && s == 8'hFA && pc == 16'h3001, "R5 R6 nmi entry",
        {p, s, pc}, {8'h34, 8'hFA, 16'h3001});
    nmi = 1'b0; irq = 1'b0;

    // R4 R6 R7 irq entry with mask clear
    pnew = 8'h30;
    pulse(pld);
    irq = 1'b1;
    @(negedge clk);
    exp_entry(16'h3001, 8'hFA, 8'h30, 1'b0);
    exp_fetch(16'h4000);
    pulse(bnd);
    drain();
    chk(p == 8'h34 && s == 8'hF7 && pc == 16'h4001, "R4 R7 irq entry",
        {p, s, pc}, {8'h34, 8'hF7, 16'h4001});
    irq = 1'b0;

    // R9 wait, woken by irq with mask set
    pulse(wai);
    repeat (5) @(negedge clk);
    chk(st == 2'd2, "R9 waiting", {30'd0, st}, 32'd2);
    exp_fetch(16'h4001);
    irq = 1'b1;
    drain();
    chk(st == 2'd1 && pc == 16'h4002 && s == 8'hF7, "R9 wake", {st, pc, s}, {2'd1, 16'h4002, 8'hF7});
    irq = 1'b0;

    // R3 one entry per edge
    nmi = 1'b1;
    @(negedge clk);
    exp_entry(16'h4002, 8'hF7, 8'h34, 1'b1);
    exp_fetch(16'h3000);
    pulse(bnd);
    drain();
    exp_fetch(16'h3001);
    pulse(bnd);
    drain();
    chk(s == 8'hF4 && pc == 16'h3002, "R3 steady nmi", {s, pc}, {8'hF4, 16'h3002});
    nmi = 1'b0;

    // R10 stopped ignores interrupts
    pulse(stp);
    irq = 1'b1;
    @(negedge clk) nmi = 1'b1;
    repeat (8) @(negedge clk);
    chk(st == 2'd3 && pc == 16'h3002 && s == 8'hF4, "R10 stopped", {st, pc, s}, {2'd3, 16'h3002, 8'hF4});
    irq = 1'b0; nmi = 1'b0;
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    chk(st == 2'd0 && s == 8'h00 && p == 8'h24, "R1 R10 reset leaves stop", {st, s, p}, {2'd0, 8'h00, 8'h24});
    exp_reset(16'h0000, 8'h00);
    exp_fetch(16'h0200);
    rst_n = 1'b1;
    drain();
    chk(st == 2'd1 && pc == 16'h0201 && s == 8'hFD, "R2 restart", {st, pc, s}, {2'd1, 16'h0201, 8'hFD});

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule